// File: doc/BRIEF.md
# Host-Programmable Table-Driven Sequencer

This block is a finite state machine whose whole behaviour lives in a writable lookup table rather than in fixed logic. On every clock while it runs, the present state and the synchronized input bits together form a table index. The word stored at that index supplies the following state and a vector of raw output bits. A host loads the table one word at a time through a small write-only register port, while the machine is held halted.

A programmable crossbar sits after the table. It gives each external control line its own select register, which picks one raw output bit or a constant zero. A new control application therefore needs only a fresh table and a fresh map, with no new logic. The typical use is to step an attached multi-plane device through its configuration planes without the host in the loop.

Host register port: writes take effect on a clock edge where `hostWe` is high. Address 0 sets the table pointer from `hostWdata[7:0]`. Address 1 writes a table word from `hostWdata[11:0]`. Address 2 holds the run bit in `hostWdata[0]`. Address 3 holds the start state in `hostWdata[3:0]`. Addresses 8 to 15 hold the select for lines 0 to 7, taken from `hostWdata[3:0]`.

Top module: `tfsm_top`

## Requirements
- R1: After reset the machine is halted, `stateOut` is 0, every line select holds the zero code, and `ctrlLines` is 0.
- R2: While halted, `stateOut` follows the start-state register (address 3) one clock later and `ctrlLines` is 0.
- R3: A write to address 1 while halted stores `hostWdata[11:0]` at the table pointer and then adds one to the pointer, wrapping from 255 to 0. A write to address 0 loads the pointer.
- R4: While running, each clock loads the state from bits 11:8 and the raw outputs from bits 7:0 of the entry whose index has the present state in bits 7:4 and the synchronized inputs in bits 3:0.
- R5: Each `fsmIn` bit passes through two flops before it forms part of the index. An input change that is applied before edge 1 is first used to form the index at edge 3.
- R6: Line i equals raw output bit s when its select value s (address 8+i) is below 8. It is 0 for select values 8 to 15.
- R7: Writes to address 1 while running are ignored: the table keeps its contents and the pointer keeps its value.
- R8: After the run bit is cleared, the state returns to the start state and the lines fall to 0 within two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWe | input | 1 | Host register write strobe |
| hostAddr | input | 4 | Host register address |
| hostWdata | input | 16 | Host register write data |
| fsmIn | input | 4 | Asynchronous condition inputs |
| ctrlLines | output | 8 | Mapped external control lines |
| stateOut | output | 4 | Present state |

## Verification
The bench goes after the pointer wrap at index 255. A pointer that saturates or fails to wrap would leave entry 0 stale, and the run that follows would take the wrong path. It checks that table writes made during a run change neither the memory nor the pointer: a later halted write must land at the pointer value that was set before the run. It counts the exact input-to-state latency through the synchronizer, where one stage too many or too few shifts the state change by a clock. It also covers select codes of 8 and above, which must hold a line low rather than fold back onto a real output bit.

// File: rtl/tfsm_pkg.sv
package tfsm_pkg;
  localparam int HOST_AW = 4;
  localparam int HOST_DW = 16;
  localparam logic [HOST_AW-1:0] REG_PTR  = 4'd0;
  localparam logic [HOST_AW-1:0] REG_DATA = 4'd1;
  localparam logic [HOST_AW-1:0] REG_RUN  = 4'd2;
  localparam logic [HOST_AW-1:0] REG_INIT = 4'd3;

  typedef struct packed {
    logic tblWe;   // accepted table word write
    logic mapWe;   // line select write
    logic run;     // machine running
  } strobe_t;
endpackage

// File: rtl/tfsm_ctrl.sv
module tfsm_ctrl
  import tfsm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ST_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  output strobe_t            strb,
  output logic [ADDR_W-1:0]  tblPtr,
  output logic [ST_W-1:0]    initState
);
  logic runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tblPtr    <= '0;
      runQ      <= 1'b0;
      initState <= '0;
    end else if (hostWe) begin
      case (hostAddr)
        REG_PTR:  tblPtr <= hostWdata[ADDR_W-1:0];
        REG_DATA: if (!runQ) tblPtr <= tblPtr + 1'b1;
        REG_RUN:  runQ <= hostWdata[0];
        REG_INIT: initState <= hostWdata[ST_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    strb.tblWe = hostWe && (hostAddr == REG_DATA) && !runQ;
    strb.mapWe = hostWe && hostAddr[HOST_AW-1];
    strb.run   = runQ;
  end
endmodule

// File: rtl/tfsm_dp.sv
module tfsm_dp
  import tfsm_pkg::*;
#(
  parameter int ST_W  = 4,
  parameter int IN_W  = 4,
  parameter int OUT_W = 8,
  parameter int LINES = 8,
  localparam int ADDR_W = ST_W + IN_W,
  localparam int WORD_W = ST_W + OUT_W,
  localparam int TBL_D  = 1 << ADDR_W,
  localparam int BIT_W  = $clog2(OUT_W),
  localparam int SEL_W  = BIT_W + 1,
  localparam int LIDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] tblPtr,
  input  logic [WORD_W-1:0] tblWord,
  input  logic [ST_W-1:0]   initState,
  input  logic [LIDX_W-1:0] mapIdx,
  input  logic [SEL_W-1:0]  mapSel,
  input  logic [IN_W-1:0]   fsmIn,
  output logic [ST_W-1:0]   stateQ,
  output logic [LINES-1:0]  ctrlLines
);
  localparam logic [SEL_W-1:0] ZERO_CODE = SEL_W'(OUT_W);

  logic [WORD_W-1:0] tbl [TBL_D];
  logic [IN_W-1:0]   syncA, syncB;
  logic [OUT_W-1:0]  rawQ;
  logic [WORD_W-1:0] rdWord;
  logic [SEL_W-1:0]  selQ [LINES];

  always_ff @(posedge clk) begin
    if (strb.tblWe) tbl[tblPtr] <= tblWord;
  end

  assign rdWord = tbl[{stateQ, syncB}];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      stateQ <= '0;
      rawQ   <= '0;
    end else begin
      syncA <= fsmIn;
      syncB <= syncA;
      if (strb.run) begin
        stateQ <= rdWord[WORD_W-1:OUT_W];
        rawQ   <= rdWord[OUT_W-1:0];
      end else begin
        stateQ <= initState;
        rawQ   <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) selQ[i] <= ZERO_CODE;
    end else if (strb.mapWe) begin
      selQ[mapIdx] <= mapSel;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign ctrlLines[g] = (selQ[g] < ZERO_CODE) ? rawQ[selQ[g][BIT_W-1:0]] : 1'b0;
  end
endmodule

// File: rtl/tfsm_top.sv
module tfsm_top
  import tfsm_pkg::*;
#(
  parameter int ST_W  = 4,
  parameter int IN_W  = 4,
  parameter int OUT_W = 8,
  parameter int LINES = 8,
  localparam int ADDR_W = ST_W + IN_W,
  localparam int WORD_W = ST_W + OUT_W,
  localparam int SEL_W  = $clog2(OUT_W) + 1,
  localparam int LIDX_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic [IN_W-1:0]    fsmIn,
  output logic [LINES-1:0]   ctrlLines,
  output logic [ST_W-1:0]    stateOut
);
  strobe_t           strb;
  logic [ADDR_W-1:0] tblPtr;
  logic [ST_W-1:0]   initState;

  tfsm_ctrl #(.ADDR_W(ADDR_W), .ST_W(ST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .strb(strb), .tblPtr(tblPtr), .initState(initState)
  );

  tfsm_dp #(.ST_W(ST_W), .IN_W(IN_W), .OUT_W(OUT_W), .LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tblPtr(tblPtr),
    .tblWord(hostWdata[WORD_W-1:0]), .initState(initState),
    .mapIdx(hostAddr[LIDX_W-1:0]), .mapSel(hostWdata[SEL_W-1:0]),
    .fsmIn(fsmIn), .stateQ(stateOut), .ctrlLines(ctrlLines)
  );
endmodule

// File: rtl/tfsm_chk.sv
module tfsm_chk
  import tfsm_pkg::*;
#(
  parameter int ST_W   = 4,
  parameter int ADDR_W = 8,
  parameter int LINES  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWe,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               run,
  input logic [ADDR_W-1:0]  ptr,
  input logic [ST_W-1:0]    initState,
  input logic [ST_W-1:0]    stateOut,
  input logic [LINES-1:0]   ctrlLines
);
  a_r2_halt_lines_low: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (ctrlLines == '0));

  a_r2_halt_follows_init: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (stateOut == $past(initState)));

  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (!run && hostWe && hostAddr == REG_DATA) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (run && hostWe && hostAddr == REG_DATA) |=> $stable(ptr));
endmodule

bind tfsm_top tfsm_chk #(.ST_W(ST_W), .ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
  .run(strb.run), .ptr(tblPtr), .initState(initState),
  .stateOut(stateOut), .ctrlLines(ctrlLines)
);

// File: tb/tb_tfsm_top.sv
module tb_tfsm_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [3:0]  fsmIn = '0;
  logic [7:0]  ctrlLines;
  logic [3:0]  stateOut;

  int checks = 0;
  int errors = 0;
  bit checkEn = 0;
  string phase = "R1";

  // reference model built from the requirements
  logic [11:0] mTbl [256];
  logic [7:0]  mPtr;
  logic        mRun;
  logic [3:0]  mInit, mState, mS1, mS2;
  logic [7:0]  mOut;
  logic [3:0]  mSel [8];

  tfsm_top dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .fsmIn(fsmIn), .ctrlLines(ctrlLines), .stateOut(stateOut)
  );

  always #2 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPtr <= 0; mRun <= 0; mInit <= 0; mState <= 0; mS1 <= 0; mS2 <= 0; mOut <= 0;
      for (int i = 0; i < 8; i++) mSel[i] <= 4'd8;
    end else begin
      mS1 <= fsmIn;
      mS2 <= mS1;
      if (mRun) begin
        mState <= mTbl[{mState, mS2}][11:8];
        mOut   <= mTbl[{mState, mS2}][7:0];
      end else begin
        mState <= mInit;
        mOut   <= 0;
      end
      if (hostWe) begin
        if (hostAddr[3]) mSel[hostAddr[2:0]] <= hostWdata[3:0];
        else case (hostAddr)
          4'd0: mPtr <= hostWdata[7:0];
          4'd1: if (!mRun) begin mTbl[mPtr] <= hostWdata[11:0]; mPtr <= mPtr + 8'd1; end
          4'd2: mRun <= hostWdata[0];
          4'd3: mInit <= hostWdata[3:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] expLines();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (mSel[i] < 4'd8) ? mOut[mSel[i][2:0]] : 1'b0;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checkEn && rstN) begin
      chk(stateOut === mState, phase, int'(stateOut), int'(mState));
      chk(ctrlLines === expLines(), "R6 line map", int'(ctrlLines), int'(expLines()));
    end
  end

  task automatic hostWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stateOut == 4'd0, "R1 state", int'(stateOut), 0);
    chk(ctrlLines == 8'd0, "R1 lines", int'(ctrlLines), 0);
    checkEn = 1;

    // R2 halted follows start state
    phase = "R2";
    hostWrite(4'd3, 16'd5);
    idle(2);
    chk(stateOut == 4'd5, "R2 state", int'(stateOut), 5);
    chk(ctrlLines == 8'd0, "R2 lines", int'(ctrlLines), 0);

    // R6 selects, including zero codes 8 and 15
    phase = "R6";
    for (int i = 0; i < 6; i++) hostWrite(4'd8 + 4'(i), 16'(7 - i));
    hostWrite(4'd14, 16'd8);
    hostWrite(4'd15, 16'd15);

    // R3 full load, then wrap across 255
    phase = "R3";
    hostWrite(4'd0, 16'd0);
    for (int i = 0; i < 256; i++) hostWrite(4'd1, 16'($urandom) & 16'h0fff);
    hostWrite(4'd0, 16'd255);
    hostWrite(4'd1, 16'h0a5c);
    hostWrite(4'd1, 16'h03e1);

    // R4 random run
    phase = "R4";
    hostWrite(4'd2, 16'd1);
    for (int i = 0; i < 300; i++) begin @(negedge clk); fsmIn = 4'($urandom); end

    // R7 writes during run ignored
    phase = "R7";
    hostWrite(4'd2, 16'd0);
    hostWrite(4'd0, 16'h0050);
    hostWrite(4'd3, 16'd5);
    fsmIn = 4'd0;
    idle(3);
    hostWrite(4'd2, 16'd1);
    for (int i = 0; i < 3; i++) hostWrite(4'd1, 16'h03ab);
    hostWrite(4'd2, 16'd0);
    idle(2);
    hostWrite(4'd1, 16'h05c3);
    hostWrite(4'd2, 16'd1);
    idle(4);
    chk(stateOut == 4'd5, "R7 entry landed at held pointer", int'(stateOut), 5);

    // R8 halt returns to start state
    phase = "R8";
    hostWrite(4'd2, 16'd0);
    idle(2);
    chk(stateOut == 4'd5, "R8 state", int'(stateOut), 5);
    chk(ctrlLines == 8'd0, "R8 lines", int'(ctrlLines), 0);

    // R5 synchronizer latency: table with next = input
    phase = "R5";
    hostWrite(4'd3, 16'd0);
    hostWrite(4'd0, 16'd0);
    for (int i = 0; i < 256; i++) hostWrite(4'd1, 16'(((i & 15) << 8) | i));
    hostWrite(4'd2, 16'd1);
    idle(4);
    chk(stateOut == 4'd0, "R5 settled", int'(stateOut), 0);
    fsmIn = 4'd9;
    idle(2);
    chk(stateOut == 4'd0, "R5 not before third edge", int'(stateOut), 0);
    idle(1);
    chk(stateOut == 4'd9, "R5 at third edge", int'(stateOut), 9);
    hostWrite(4'd2, 16'd0);
    idle(2);

    // mixed random rounds
    for (int r = 0; r < 4; r++) begin
      phase = "R4";
      for (int i = 0; i < 8; i++) hostWrite(4'd8 + 4'(i), 16'($urandom_range(0, 15)));
      hostWrite(4'd0, 16'd0);
      for (int i = 0; i < 256; i++) hostWrite(4'd1, 16'($urandom) & 16'h0fff);
      hostWrite(4'd3, 16'($urandom_range(0, 15)));
      hostWrite(4'd2, 16'd1);
      for (int i = 0; i < 200; i++) begin @(negedge clk); fsmIn = 4'($urandom); end
      phase = "R8";
      hostWrite(4'd2, 16'd0);
      idle(2);
      chk(ctrlLines == 8'd0, "R8 lines after halt", int'(ctrlLines), 0);
    end

    checkEn = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule